// File: doc/BRIEF.md
# Reordering Message Buffer

This block stands between a 32-bit write port and a word-serial cipher round engine. It collects a message of 2 to 8 words and raises a data-available flag once the configured count has arrived. It presents the words as parallel slots, and slot i feeds engine register i directly. In encryption the words fill the slots in arrival order. In decryption each new word enters slot 0 and the older words move one slot up, so the stored order is reversed. Because of this, the engine can use a single shift direction in both modes.

On the result side, a capture pulse copies the engine's words into an output buffer. Each shift-enable pulse then sends out one 32-bit word with a valid strobe, for exactly the configured number of words. In decryption the captured words are sent out from the highest used slot down to slot 0. The recovered plaintext therefore leaves in its natural order.

Top module: `msg_reorder_buf`

## Requirements
- R1: In encryption mode (`decMode`=0), the k-th accepted write after a clear (k counted from 0) is stored in slot k. Slot k is bits [32k+31:32k] of `msgWords`.
- R2: In decryption mode (`decMode`=1), every accepted write goes into slot 0 and moves slot i into slot i+1. After n writes, slot i holds write number n-1-i.
- R3: `dataAvail` stays low until n words have been accepted. It goes high in the cycle after the n-th accepted write.
- R4: A write presented while `dataAvail` is high is ignored. The slots and the flag keep their values.
- R5: `loadPulse` clears `dataAvail` and the word counter. The next accepted write is again the first word of a message.
- R6: The effective count n is `wordCount` clamped to the range 2..8. A value of 0 or 1 acts as 2, and a value of 9 to 15 acts as 8.
- R7: `resUpdate` captures `resIn` and arms n outputs. Each `shiftEn` cycle that has words left drives `dataOutValid` high with one word in the next cycle. `shiftEn` has no effect once the n words are gone or while no capture has been made.
- R8: In encryption the output order is result slot 0 first, then upward. In decryption it is result slot n-1 first, then down to slot 0. The mode is taken at the capture.
- R9: `dataOut` is zero in every cycle in which `dataOutValid` is low.
- R10: After reset, `dataAvail` and `dataOutValid` are low and `dataOut` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Write strobe for `wrData` |
| wrData | input | 32 | Incoming message word |
| decMode | input | 1 | 0 = encryption ordering, 1 = decryption ordering |
| wordCount | input | 4 | Words per message, clamped to 2..8 |
| loadPulse | input | 1 | Engine has taken the slots; clear for the next message |
| resUpdate | input | 1 | Capture `resIn` into the output buffer |
| resIn | input | 256 | Engine result words, slot i at bits [32i+31:32i] |
| shiftEn | input | 1 | Request the next output word |
| msgWords | output | 256 | Parallel slots, slot i at bits [32i+31:32i] |
| dataAvail | output | 1 | A complete message is held |
| dataOut | output | 32 | Serial result word |
| dataOutValid | output | 1 | `dataOut` carries a result word |

## Verification
A fill counter that is off by one shows up at once: `dataAvail` rises one write early or late, and every later word lands in the wrong slot. A broken push chain in decryption exchanges slot contents, and this shows as soon as the flag rises. A wrong remaining-word count on the output side gives an extra or a missing valid strobe in the cycle after the last intended shift. A wrong capture order puts the words out in the wrong sequence from the first output word on.

// File: rtl/msgbuf_pkg.sv
package msgbuf_pkg;
  // strobes issued by the control to the datapath for one cycle
  typedef struct packed {
    logic acceptWr;   // store wrData this cycle
    logic pushChain;  // decryption ordering: push at slot 0
    logic capRes;     // load result buffer
    logic capReverse; // reverse the used slots while loading
    logic emitWord;   // shift one word out
  } bufStrobes_t;
endpackage

// File: rtl/msgbuf_ctrl.sv
module msgbuf_ctrl
  import msgbuf_pkg::*;
#(
  parameter int MIN_WORDS = 2,
  parameter int MAX_WORDS = 8,
  localparam int CNT_W  = $clog2(MAX_WORDS + 1),
  localparam int SLOT_W = $clog2(MAX_WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              decMode,
  input  logic [CNT_W-1:0]  wordCount,
  input  logic              loadPulse,
  input  logic              resUpdate,
  input  logic              shiftEn,
  output bufStrobes_t       strb,
  output logic [SLOT_W-1:0] wrSlot,
  output logic [CNT_W-1:0]  nWords,
  output logic              dataAvail
);
  localparam logic [CNT_W-1:0] MinCnt = CNT_W'(MIN_WORDS);
  localparam logic [CNT_W-1:0] MaxCnt = CNT_W'(MAX_WORDS);

  logic [CNT_W-1:0] fillCnt;
  logic [CNT_W-1:0] outLeft;
  logic             availQ;
  logic [CNT_W-1:0] fillNext;

  always_comb begin
    if (wordCount < MinCnt)      nWords = MinCnt;
    else if (wordCount > MaxCnt) nWords = MaxCnt;
    else                         nWords = wordCount;
  end

  always_comb begin
    strb.acceptWr   = wrEn && !availQ && !loadPulse;
    strb.pushChain  = decMode;
    strb.capRes     = resUpdate;
    strb.capReverse = decMode;
    strb.emitWord   = shiftEn && !resUpdate && (outLeft != '0);
  end

  assign fillNext  = fillCnt + CNT_W'(1);
  assign wrSlot    = fillCnt[SLOT_W-1:0];
  assign dataAvail = availQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fillCnt <= '0;
      availQ  <= 1'b0;
    end else if (loadPulse) begin
      fillCnt <= '0;
      availQ  <= 1'b0;
    end else if (strb.acceptWr) begin
      fillCnt <= fillNext;
      if (fillNext == nWords) availQ <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              outLeft <= '0;
    else if (resUpdate)     outLeft <= nWords;
    else if (strb.emitWord) outLeft <= outLeft - CNT_W'(1);
  end
endmodule

// File: rtl/msgbuf_dpath.sv
module msgbuf_dpath
  import msgbuf_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int MAX_WORDS = 8,
  localparam int CNT_W  = $clog2(MAX_WORDS + 1),
  localparam int SLOT_W = $clog2(MAX_WORDS),
  localparam int FLAT_W = WORD_W * MAX_WORDS
) (
  input  logic              clk,
  input  logic              rstN,
  input  bufStrobes_t       strb,
  input  logic [SLOT_W-1:0] wrSlot,
  input  logic [CNT_W-1:0]  nWords,
  input  logic [WORD_W-1:0] wrData,
  input  logic [FLAT_W-1:0] resIn,
  output logic [FLAT_W-1:0] msgWords,
  output logic [WORD_W-1:0] dataOut,
  output logic              dataOutValid
);
  logic [WORD_W-1:0] slot   [MAX_WORDS];
  logic [WORD_W-1:0] rbuf   [MAX_WORDS];
  logic [WORD_W-1:0] resArr [MAX_WORDS];
  logic [WORD_W-1:0] capVal [MAX_WORDS];

  for (genvar i = 0; i < MAX_WORDS; i++) begin : g_word
    logic [CNT_W-1:0] revIdx;
    logic             inRange;

    assign resArr[i] = resIn[i*WORD_W +: WORD_W];
    assign msgWords[i*WORD_W +: WORD_W] = slot[i];
    assign revIdx  = nWords - CNT_W'(i) - CNT_W'(1);
    assign inRange = CNT_W'(i) < nWords;

    always_comb begin
      if (strb.capReverse && inRange) capVal[i] = resArr[revIdx[SLOT_W-1:0]];
      else                            capVal[i] = resArr[i];
    end

    // message slot: direct write or push chain
    if (i == 0) begin : g_head
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) slot[i] <= '0;
        else if (strb.acceptWr && (strb.pushChain || wrSlot == SLOT_W'(i)))
          slot[i] <= wrData;
      end
    end else begin : g_tail
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) slot[i] <= '0;
        else if (strb.acceptWr) begin
          if (strb.pushChain)              slot[i] <= slot[i-1];
          else if (wrSlot == SLOT_W'(i))   slot[i] <= wrData;
        end
      end
    end

    // result buffer: shifts toward slot 0
    if (i == MAX_WORDS - 1) begin : g_rtop
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)              rbuf[i] <= '0;
        else if (strb.capRes)   rbuf[i] <= capVal[i];
        else if (strb.emitWord) rbuf[i] <= '0;
      end
    end else begin : g_rlow
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)              rbuf[i] <= '0;
        else if (strb.capRes)   rbuf[i] <= capVal[i];
        else if (strb.emitWord) rbuf[i] <= rbuf[i+1];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataOut      <= '0;
      dataOutValid <= 1'b0;
    end else begin
      dataOutValid <= strb.emitWord;
      dataOut      <= strb.emitWord ? rbuf[0] : '0;
    end
  end
endmodule

// File: rtl/msg_reorder_buf.sv
module msg_reorder_buf
  import msgbuf_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int MIN_WORDS = 2,
  parameter int MAX_WORDS = 8,
  localparam int CNT_W  = $clog2(MAX_WORDS + 1),
  localparam int SLOT_W = $clog2(MAX_WORDS),
  localparam int FLAT_W = WORD_W * MAX_WORDS
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [WORD_W-1:0] wrData,
  input  logic              decMode,
  input  logic [CNT_W-1:0]  wordCount,
  input  logic              loadPulse,
  input  logic              resUpdate,
  input  logic [FLAT_W-1:0] resIn,
  input  logic              shiftEn,
  output logic [FLAT_W-1:0] msgWords,
  output logic              dataAvail,
  output logic [WORD_W-1:0] dataOut,
  output logic              dataOutValid
);
  bufStrobes_t       strb;
  logic [SLOT_W-1:0] wrSlot;
  logic [CNT_W-1:0]  nWords;

  msgbuf_ctrl #(.MIN_WORDS(MIN_WORDS), .MAX_WORDS(MAX_WORDS)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .decMode(decMode),
    .wordCount(wordCount), .loadPulse(loadPulse), .resUpdate(resUpdate),
    .shiftEn(shiftEn), .strb(strb), .wrSlot(wrSlot), .nWords(nWords),
    .dataAvail(dataAvail)
  );

  msgbuf_dpath #(.WORD_W(WORD_W), .MAX_WORDS(MAX_WORDS)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .wrSlot(wrSlot), .nWords(nWords),
    .wrData(wrData), .resIn(resIn), .msgWords(msgWords), .dataOut(dataOut),
    .dataOutValid(dataOutValid)
  );
endmodule

// File: rtl/msgbuf_chk.sv
module msgbuf_chk #(
  parameter int WORD_W    = 32,
  parameter int MAX_WORDS = 8,
  localparam int CNT_W  = $clog2(MAX_WORDS + 1),
  localparam int FLAT_W = WORD_W * MAX_WORDS
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic              loadPulse,
  input logic              resUpdate,
  input logic              shiftEn,
  input logic [FLAT_W-1:0] msgWords,
  input logic              dataAvail,
  input logic [WORD_W-1:0] dataOut,
  input logic              dataOutValid
);
  // R3: the flag only rises right after a write strobe
  assert_avail_after_write_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dataAvail) |-> $past(wrEn));

  // R4: a held message is frozen until the engine takes it
  assert_hold_while_avail_R4: assert property (@(posedge clk) disable iff (!rstN)
    (dataAvail && !loadPulse) |=> (dataAvail && $stable(msgWords)));

  // R5: taking the data clears the flag
  assert_load_clears_R5: assert property (@(posedge clk) disable iff (!rstN)
    loadPulse |=> !dataAvail);

  // R7: no output strobe without a shift request
  assert_valid_needs_shift_R7: assert property (@(posedge clk) disable iff (!rstN)
    !shiftEn |=> !dataOutValid);

  // R7: a capture cycle emits nothing
  assert_capture_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    resUpdate |=> !dataOutValid);

  // R9: idle output bus is zero
  assert_idle_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    !dataOutValid |-> (dataOut == '0));
endmodule

bind msg_reorder_buf msgbuf_chk #(.WORD_W(WORD_W), .MAX_WORDS(MAX_WORDS)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .loadPulse(loadPulse),
  .resUpdate(resUpdate), .shiftEn(shiftEn), .msgWords(msgWords),
  .dataAvail(dataAvail), .dataOut(dataOut), .dataOutValid(dataOutValid)
);

// File: tb/sim_msg_reorder_buf.sv
module sim_msg_reorder_buf;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         wrEn = 1'b0;
  logic [31:0]  wrData = '0;
  logic         decMode = 1'b0;
  logic [3:0]   wordCount = 4'd2;
  logic         loadPulse = 1'b0;
  logic         resUpdate = 1'b0;
  logic [255:0] resIn = '0;
  logic         shiftEn = 1'b0;
  logic [255:0] msgWords;
  logic         dataAvail;
  logic [31:0]  dataOut;
  logic         dataOutValid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] sbQ [$];      // expected serial words, pushed by driver
  logic [31:0] pendQ [$];    // words armed by the last capture

  always #4 clk = ~clk;

  msg_reorder_buf u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .decMode(decMode),
    .wordCount(wordCount), .loadPulse(loadPulse), .resUpdate(resUpdate),
    .resIn(resIn), .shiftEn(shiftEn), .msgWords(msgWords),
    .dataAvail(dataAvail), .dataOut(dataOut), .dataOutValid(dataOutValid)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] slotOf(input int i);
    return msgWords[i*32 +: 32];
  endfunction

  // all drivers start and end at a falling edge
  task automatic writeWord(input logic [31:0] d);
    wrEn = 1'b1; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic pulseLoad();
    loadPulse = 1'b1;
    @(negedge clk);
    loadPulse = 1'b0;
  endtask

  task automatic capture(input int n, input bit dec, input logic [31:0] base);
    for (int i = 0; i < 8; i++) resIn[i*32 +: 32] = base + 32'(i);
    pendQ.delete();
    for (int k = 0; k < n; k++)
      pendQ.push_back(dec ? base + 32'(n - 1 - k) : base + 32'(k));
    decMode = dec;
    resUpdate = 1'b1;
    @(negedge clk);
    resUpdate = 1'b0;
  endtask

  task automatic shiftOne();
    shiftEn = 1'b1;
    if (pendQ.size() > 0) sbQ.push_back(pendQ.pop_front());
    @(negedge clk);
    shiftEn = 1'b0;
  endtask

  // monitor: compares serial output against the scoreboard (R7, R8, R9)
  always @(negedge clk) begin
    if (rstN && !done) begin
      if (dataOutValid) begin
        if (sbQ.size() == 0) check(1'b0, "R7 unexpected valid", dataOut, 32'h0);
        else begin
          logic [31:0] e;
          e = sbQ.pop_front();
          check(dataOut == e, "R8 output word order", dataOut, e);
        end
      end else if (dataOut != 32'h0) begin
        check(1'b0, "R9 idle bus nonzero", dataOut, 32'h0);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    check(dataAvail == 1'b0, "R10 dataAvail after reset", 32'(dataAvail), 32'h0);
    check(dataOutValid == 1'b0, "R10 valid after reset", 32'(dataOutValid), 32'h0);
    check(dataOut == 32'h0, "R10 dataOut after reset", dataOut, 32'h0);

    // R1, R3: encryption fill of 3 words
    decMode = 1'b0; wordCount = 4'd3;
    writeWord(32'hA000_0000);
    writeWord(32'hA000_0001);
    check(dataAvail == 1'b0, "R3 flag early", 32'(dataAvail), 32'h0);
    writeWord(32'hA000_0002);
    check(dataAvail == 1'b1, "R3 flag after nth write", 32'(dataAvail), 32'h1);
    for (int i = 0; i < 3; i++)
      check(slotOf(i) == 32'hA000_0000 + 32'(i), "R1 encryption slot", slotOf(i),
            32'hA000_0000 + 32'(i));

    // R4: writes ignored while held
    writeWord(32'hDEAD_BEEF);
    writeWord(32'hDEAD_BEEE);
    check(dataAvail == 1'b1, "R4 flag held", 32'(dataAvail), 32'h1);
    for (int i = 0; i < 3; i++)
      check(slotOf(i) == 32'hA000_0000 + 32'(i), "R4 slot unchanged", slotOf(i),
            32'hA000_0000 + 32'(i));

    // R5: load clears, refill starts at slot 0
    pulseLoad();
    check(dataAvail == 1'b0, "R5 flag cleared", 32'(dataAvail), 32'h0);
    writeWord(32'hB000_0000);
    check(slotOf(0) == 32'hB000_0000, "R5 restart at slot 0", slotOf(0), 32'hB000_0000);
    check(dataAvail == 1'b0, "R5 counter cleared", 32'(dataAvail), 32'h0);
    pulseLoad();

    // R2: decryption fill of 4 words, reversed storage
    decMode = 1'b1; wordCount = 4'd4;
    for (int k = 0; k < 4; k++) writeWord(32'hC000_0000 + 32'(k));
    check(dataAvail == 1'b1, "R3 flag decryption", 32'(dataAvail), 32'h1);
    for (int i = 0; i < 4; i++)
      check(slotOf(i) == 32'hC000_0000 + 32'(3 - i), "R2 decryption slot", slotOf(i),
            32'hC000_0000 + 32'(3 - i));
    pulseLoad();

    // R2: shortest decryption message
    wordCount = 4'd2;
    writeWord(32'hD000_0000);
    writeWord(32'hD000_0001);
    check(slotOf(0) == 32'hD000_0001, "R2 two-word slot0", slotOf(0), 32'hD000_0001);
    check(slotOf(1) == 32'hD000_0000, "R2 two-word slot1", slotOf(1), 32'hD000_0000);
    pulseLoad();

    // R6: count below range acts as 2
    decMode = 1'b0; wordCount = 4'd0;
    writeWord(32'hE000_0000);
    check(dataAvail == 1'b0, "R6 low clamp early", 32'(dataAvail), 32'h0);
    writeWord(32'hE000_0001);
    check(dataAvail == 1'b1, "R6 low clamp at two", 32'(dataAvail), 32'h1);
    pulseLoad();

    // R6, R1: count above range acts as 8
    wordCount = 4'd15;
    for (int k = 0; k < 7; k++) writeWord(32'hF000_0000 + 32'(k));
    check(dataAvail == 1'b0, "R6 high clamp early", 32'(dataAvail), 32'h0);
    writeWord(32'hF000_0007);
    check(dataAvail == 1'b1, "R6 high clamp at eight", 32'(dataAvail), 32'h1);
    for (int i = 0; i < 8; i++)
      check(slotOf(i) == 32'hF000_0000 + 32'(i), "R1 eight-word slot", slotOf(i),
            32'hF000_0000 + 32'(i));
    pulseLoad();

    // R7: shift before any capture does nothing
    shiftOne();
    @(negedge clk);
    check(dataOutValid == 1'b0, "R7 no capture no output", 32'(dataOutValid), 32'h0);

    // R7, R8: encryption output of 3 words, then one extra shift
    wordCount = 4'd3;
    capture(3, 1'b0, 32'h5000_0000);
    shiftOne();
    @(negedge clk);               // gap, R9 checked by monitor
    shiftOne();
    shiftOne();
    shiftOne();                   // extra: must give nothing
    repeat (2) @(negedge clk);
    check(sbQ.size() == 0, "R7 encryption words all seen", 32'(sbQ.size()), 32'h0);

    // R7, R8: decryption output of 4 words, reversed
    wordCount = 4'd4;
    capture(4, 1'b1, 32'h6000_0000);
    for (int k = 0; k < 5; k++) shiftOne();
    repeat (2) @(negedge clk);
    check(sbQ.size() == 0, "R8 decryption words all seen", 32'(sbQ.size()), 32'h0);

    // R8: eight-word decryption output
    wordCount = 4'd8;
    capture(8, 1'b1, 32'h7000_0000);
    for (int k = 0; k < 9; k++) shiftOne();
    repeat (2) @(negedge clk);
    check(sbQ.size() == 0, "R8 eight-word words all seen", 32'(sbQ.size()), 32'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule